// File: doc/BRIEF.md
# Peripheral I/O Space Access Controller

This block sits between a small 8-bit processor core and its peripheral register file. Every request is one of three kinds. A port-style access carries a 6-bit I/O address. A data-space load or store carries an 8-bit address. A single-bit operation sets, clears or tests one bit of a low I/O register. The block maps all three onto one unified register address. Reads are returned combinationally, in the same cycle as the request.

A data-space address reaches the same register as the I/O address that is 0x20 lower. Data addresses 0x60 and above form an extended window that only loads and stores can reach. Data addresses below 0x20 are not I/O at all: they are handed to a separate working-register or memory port. A bit set or bit clear becomes a strobe on exactly one bit and never a read-modify-write. Because of this, write-one-to-clear status flags that share a register with the addressed bit keep their state.

The register file in this block holds three general-purpose registers, one write-one-to-clear status register that a hardware event input can set, and one narrow extended register. These registers let every mapping and corner case be tested.

Top module: `io_space_ctrl`

## Requirements
- R1: A port read (op 0) or port write (op 1) uses req_addr[5:0] as the I/O address, and req_addr[7:6] are ignored. A port write followed by a port read of the same address returns the written byte. GPR0 is at I/O 0x1E, GPR1 at 0x2A, GPR2 at 0x2B and the status register at 0x15.
- R2: A data read (op 2) or data write (op 3) at data address A ≥ 0x20 reaches the register whose I/O address is A − 0x20. The same register is reachable through both windows.
- R3: A data access with req_addr below 0x20 raises mem_req, drives mem_addr with req_addr, drives mem_we high for a write and mem_wdata with req_wdata. The register file is not changed, and rd_data is 0.
- R4: The extended register sits at data address 0xA0 and holds 4 bits. It is reachable only by data accesses. A port write whose req_addr has bit 7 set cannot alter it.
- R5: A bit set (op 4) or bit clear (op 5) on bit req_bit of a general-purpose register changes only that bit.
- R6: A status flag is set by a one on stat_evt[i]. A flag is cleared by a byte write with a one in its position, or by a bit set on it. A bit clear on the status register has no effect.
- R7: When stat_evt[i] and a clear of flag i occur in the same cycle, the flag ends set.
- R8: Reserved bits read as zero. These are status bits 7:5 and extended-register bits 7:4.
- R9: A bit operation (op 4, 5 or 6) whose req_addr[5:0] is above 0x1F changes no register. It drives bit_err high for exactly the following cycle. In every other case bit_err stays low.
- R10: A bit test (op 6) drives bit_val with the addressed bit in the same cycle and changes no register. bit_val is 0 for any other op.
- R11: Writes to unmapped I/O addresses are dropped, and reads from unmapped addresses return 0.
- R12: After reset, every register reads 0 and bit_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 port read, 1 port write, 2 data read, 3 data write, 4 bit set, 5 bit clear, 6 bit test, 7 none |
| req_addr | input | 8 | I/O address (low 6 bits) or data-space address |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Write data |
| stat_evt | input | 5 | Hardware events that set status flags |
| rd_data | output | 8 | Read data for I/O reads, 0 otherwise |
| bit_val | output | 1 | Result of a bit test |
| bit_err | output | 1 | One-cycle pulse after an out-of-range bit operation |
| mem_req | output | 1 | Data access passed to the working-register/memory port |
| mem_we | output | 1 | Passed access is a write |
| mem_addr | output | 8 | Passed access address |
| mem_wdata | output | 8 | Passed access write data |

## Verification
A hardware status event and a software clear of the same flag can fall in the same cycle. The clear may come from a byte write with ones or from a single-bit set. The bench drives stat_evt together with each form of clear on the same bit, and in one case alongside clears of other bits. Its model applies the clear first and the event afterwards, so the targeted flag must read back as set while the other cleared flags read back as zero. A checker property also demands that every flag raised by an event is set in the following cycle, whatever write happened alongside it.

// File: rtl/io_space_pkg.sv
package io_space_pkg;
  typedef enum logic [2:0] {
    OP_PRD  = 3'd0,
    OP_PWR  = 3'd1,
    OP_DRD  = 3'd2,
    OP_DWR  = 3'd3,
    OP_BSET = 3'd4,
    OP_BCLR = 3'd5,
    OP_BTST = 3'd6,
    OP_NONE = 3'd7
  } io_op_e;

  localparam int unsigned AW        = 8;
  localparam int unsigned PORT_AW   = 6;
  localparam logic [AW-1:0] DATA_OFS  = 8'h20;
  localparam logic [PORT_AW-1:0] BIT_LIMIT = 6'h20;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_space_pkg::*;
(
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] io_addr,
  output logic          io_rd,
  output logic          io_wr,
  output logic          bit_set,
  output logic          bit_clr,
  output logic          bit_tst,
  output logic          bit_bad,
  output logic          mem_req,
  output logic          mem_we
);
  io_op_e              op;
  logic [PORT_AW-1:0]  port_a;
  logic                bit_in_range;
  logic                data_low;

  assign op           = io_op_e'(req_op);
  assign port_a       = req_addr[PORT_AW-1:0];
  assign bit_in_range = port_a < BIT_LIMIT;
  assign data_low     = req_addr < DATA_OFS;

  always_comb begin
    io_addr = {{(AW-PORT_AW){1'b0}}, port_a};
    io_rd   = 1'b0;
    io_wr   = 1'b0;
    bit_set = 1'b0;
    bit_clr = 1'b0;
    bit_tst = 1'b0;
    bit_bad = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_PRD: io_rd = 1'b1;
        OP_PWR: io_wr = 1'b1;
        OP_DRD, OP_DWR: begin
          if (data_low) begin
            mem_req = 1'b1;
            mem_we  = (op == OP_DWR);
          end else begin
            io_addr = req_addr - DATA_OFS;
            io_rd   = (op == OP_DRD);
            io_wr   = (op == OP_DWR);
          end
        end
        OP_BSET, OP_BCLR, OP_BTST: begin
          if (bit_in_range) begin
            bit_set = (op == OP_BSET);
            bit_clr = (op == OP_BCLR);
            bit_tst = (op == OP_BTST);
          end else begin
            bit_bad = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/io_w1c_flags.sv
module io_w1c_flags #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] evt,
  output logic [W-1:0] flags_q
);
  logic [W-1:0] flags_d;
  logic         flags_en;

  always_comb begin
    flags_en = (|clr_mask) | (|evt);
    flags_d  = (flags_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/io_reg_file.sv
module io_reg_file
  import io_space_pkg::*;
#(
  parameter int unsigned           NUM_GPR   = 3,
  parameter logic [NUM_GPR*AW-1:0] GPR_ADDRS = {8'h2B, 8'h2A, 8'h1E},
  parameter logic [AW-1:0]         STAT_ADDR = 8'h15,
  parameter int unsigned           STAT_W    = 5,
  parameter logic [AW-1:0]         EXT_ADDR  = 8'h80,
  parameter int unsigned           EXT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              bset,
  input  logic              bclr,
  input  logic [2:0]        bidx,
  input  logic [STAT_W-1:0] stat_evt,
  output logic [7:0]        rd_byte
);
  logic [7:0]               bmask;
  logic [NUM_GPR-1:0][7:0]  gpr_q;
  logic [STAT_W-1:0]        stat_q;
  logic [STAT_W-1:0]        stat_clr;
  logic                     stat_hit;
  logic [EXT_W-1:0]         ext_q;
  logic [EXT_W-1:0]         ext_d;
  logic                     ext_en;

  assign bmask = 8'b1 << bidx;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    logic       hit;
    logic       en;
    logic [7:0] d;
    assign hit = (addr == GPR_ADDRS[g*AW +: AW]);
    always_comb begin
      en = hit & (wr | bset | bclr);
      if (wr)        d = wdata;
      else if (bset) d = gpr_q[g] | bmask;
      else           d = gpr_q[g] & ~bmask;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  gpr_q[g] <= '0;
      else if (en) gpr_q[g] <= d;
    end
  end

  assign stat_hit = (addr == STAT_ADDR);

  always_comb begin
    stat_clr = '0;
    if (stat_hit && wr)   stat_clr = wdata[STAT_W-1:0];
    if (stat_hit && bset) stat_clr = bmask[STAT_W-1:0];
  end

  io_w1c_flags #(.W(STAT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_mask (stat_clr),
    .evt      (stat_evt),
    .flags_q  (stat_q)
  );

  always_comb begin
    ext_en = wr && (addr == EXT_ADDR);
    ext_d  = wdata[EXT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= '0;
    else if (ext_en) ext_q <= ext_d;
  end

  always_comb begin
    rd_byte = '0;
    for (int g = 0; g < NUM_GPR; g++) begin
      if (addr == GPR_ADDRS[g*AW +: AW]) rd_byte = gpr_q[g];
    end
    if (stat_hit)          rd_byte[STAT_W-1:0] = stat_q;
    if (addr == EXT_ADDR)  rd_byte[EXT_W-1:0]  = ext_q;
  end
endmodule

// File: rtl/io_space_ctrl.sv
module io_space_ctrl
  import io_space_pkg::*;
#(
  parameter int unsigned           NUM_GPR   = 3,
  parameter logic [NUM_GPR*8-1:0]  GPR_ADDRS = {8'h2B, 8'h2A, 8'h1E},
  parameter logic [7:0]            STAT_ADDR = 8'h15,
  parameter int unsigned           STAT_W    = 5,
  parameter logic [7:0]            EXT_ADDR  = 8'h80,
  parameter int unsigned           EXT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [7:0]        req_addr,
  input  logic [2:0]        req_bit,
  input  logic [7:0]        req_wdata,
  input  logic [STAT_W-1:0] stat_evt,
  output logic [7:0]        rd_data,
  output logic              bit_val,
  output logic              bit_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [7:0]        mem_addr,
  output logic [7:0]        mem_wdata
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic [7:0] io_addr;
  logic       io_rd, io_wr, bit_set, bit_clr, bit_tst, bit_bad;
  logic       dec_mem_req, dec_mem_we;
  logic [7:0] rd_byte;
  logic       err_d, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  io_addr_decode u_dec (
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .bit_set   (bit_set),
    .bit_clr   (bit_clr),
    .bit_tst   (bit_tst),
    .bit_bad   (bit_bad),
    .mem_req   (dec_mem_req),
    .mem_we    (dec_mem_we)
  );

  io_reg_file #(
    .NUM_GPR   (NUM_GPR),
    .GPR_ADDRS (GPR_ADDRS),
    .STAT_ADDR (STAT_ADDR),
    .STAT_W    (STAT_W),
    .EXT_ADDR  (EXT_ADDR),
    .EXT_W     (EXT_W)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_sn),
    .addr     (io_addr),
    .wr       (io_wr),
    .wdata    (req_wdata),
    .bset     (bit_set),
    .bclr     (bit_clr),
    .bidx     (req_bit),
    .stat_evt (stat_evt),
    .rd_byte  (rd_byte)
  );

  assign err_d = bit_bad;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  always_comb begin
    rd_data   = io_rd ? rd_byte : 8'h00;
    bit_val   = bit_tst ? rd_byte[req_bit] : 1'b0;
    bit_err   = err_q;
    mem_req   = dec_mem_req;
    mem_we    = dec_mem_we;
    mem_addr  = dec_mem_req ? req_addr : 8'h00;
    mem_wdata = dec_mem_we ? req_wdata : 8'h00;
  end
endmodule

// File: rtl/io_space_ctrl_chk.sv
module io_space_ctrl_chk #(
  parameter int unsigned NUM_GPR   = 3,
  parameter int unsigned STAT_W    = 5,
  parameter int unsigned EXT_W     = 4,
  parameter logic [7:0]  STAT_ADDR = 8'h15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [2:0]           req_op,
  input logic [7:0]           req_addr,
  input logic [STAT_W-1:0]    stat_evt,
  input logic [7:0]           rd_data,
  input logic                 bit_err,
  input logic                 mem_req,
  input logic [STAT_W-1:0]    stat_q,
  input logic [NUM_GPR*8-1:0] gpr_q,
  input logic [EXT_W-1:0]     ext_q
);
  logic bad_bitop;
  assign bad_bitop = req_valid && (req_op inside {3'd4, 3'd5, 3'd6}) && req_addr[5];

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(bad_bitop));

  p_err_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_bitop |=> bit_err);

  p_mem_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && stat_evt == '0) |=> ($stable(stat_q) && $stable(gpr_q) && $stable(ext_q)));

  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_evt != '0) |=> ((stat_q & $past(stat_evt)) == $past(stat_evt)));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && req_addr[5:0] == STAT_ADDR[5:0]) |-> (rd_data[7:STAT_W] == '0));

  p_test_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd6 && stat_evt == '0) |=> ($stable(stat_q) && $stable(gpr_q) && $stable(ext_q)));

  p_port_no_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1) |=> $stable(ext_q));
endmodule

bind io_space_ctrl io_space_ctrl_chk #(
  .NUM_GPR   (NUM_GPR),
  .STAT_W    (STAT_W),
  .EXT_W     (EXT_W),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .stat_evt  (stat_evt),
  .rd_data   (rd_data),
  .bit_err   (bit_err),
  .mem_req   (mem_req),
  .stat_q    (u_rf.stat_q),
  .gpr_q     (u_rf.gpr_q),
  .ext_q     (u_rf.ext_q)
);

// File: tb/io_space_ctrl_tb_top.sv
module io_space_ctrl_tb_top;
  localparam int PRD = 0, PWR = 1, DRD = 2, DWR = 3, BSET = 4, BCLR = 5, BTST = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_op;
  logic [7:0] req_addr;
  logic [2:0] req_bit;
  logic [7:0] req_wdata;
  logic [4:0] stat_evt;
  logic [7:0] rd_data;
  logic       bit_val, bit_err, mem_req, mem_we;
  logic [7:0] mem_addr, mem_wdata;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  logic [7:0] m_gpr [3];
  logic [4:0] m_stat;
  logic [3:0] m_ext;
  logic       exp_err;
  string      prev_tag;

  always #5 clk = ~clk;

  io_space_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
    .stat_evt(stat_evt), .rd_data(rd_data), .bit_val(bit_val),
    .bit_err(bit_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] ua);
    case (ua)
      8'h1E:   return m_gpr[0];
      8'h2A:   return m_gpr[1];
      8'h2B:   return m_gpr[2];
      8'h15:   return {3'b000, m_stat};
      8'h80:   return {4'h0, m_ext};
      default: return 8'h00;
    endcase
  endfunction

  task automatic op(input int o, input logic [7:0] a, input logic [2:0] b,
                    input logic [7:0] wd, input logic [4:0] evt, input string tag);
    logic [7:0] ua, e_rd, e_madr, e_mwd;
    logic       is_rd, is_wr, is_mem, e_mwe, bset, bclr, btst, bad, e_bv;
    logic [4:0] clr;
    @(negedge clk);
    chk({prev_tag, " R9"}, "bit_err", {7'b0, bit_err}, {7'b0, exp_err});
    req_valid = 1'b1; req_op = 3'(o); req_addr = a; req_bit = b;
    req_wdata = wd; stat_evt = evt;
    #1;
    ua = {2'b00, a[5:0]};
    is_rd = (o == PRD); is_wr = (o == PWR); is_mem = 1'b0;
    if (o == DRD || o == DWR) begin
      if (a < 8'h20) is_mem = 1'b1;
      else begin ua = a - 8'h20; is_rd = (o == DRD); is_wr = (o == DWR); end
    end
    bad  = (o >= BSET && o <= BTST) && (a[5:0] > 6'h1F);
    bset = (o == BSET) && !bad;
    bclr = (o == BCLR) && !bad;
    btst = (o == BTST) && !bad;
    e_rd   = is_rd ? m_read(ua) : 8'h00;
    e_bv   = btst ? m_read(ua)[b] : 1'b0;
    e_mwe  = is_mem && (o == DWR);
    e_madr = is_mem ? a : 8'h00;
    e_mwd  = e_mwe ? wd : 8'h00;
    chk(tag, "rd_data", rd_data, e_rd);
    chk(tag, "bit_val", {7'b0, bit_val}, {7'b0, e_bv});
    chk(tag, "mem_req", {7'b0, mem_req}, {7'b0, is_mem});
    chk(tag, "mem_we", {7'b0, mem_we}, {7'b0, e_mwe});
    chk(tag, "mem_addr", mem_addr, e_madr);
    chk(tag, "mem_wdata", mem_wdata, e_mwd);
    @(posedge clk);
    clr = 5'b0;
    if (is_wr) begin
      case (ua)
        8'h1E: m_gpr[0] = wd;
        8'h2A: m_gpr[1] = wd;
        8'h2B: m_gpr[2] = wd;
        8'h15: clr = wd[4:0];
        8'h80: m_ext = wd[3:0];
        default: ;
      endcase
    end
    if (bset || bclr) begin
      case (ua)
        8'h1E: m_gpr[0][b] = bset;
        8'h2A: m_gpr[1][b] = bset;
        8'h2B: m_gpr[2][b] = bset;
        8'h15: if (bset && b < 3'd5) clr[b] = 1'b1;
        default: ;
      endcase
    end
    m_stat   = (m_stat & ~clr) | evt;
    exp_err  = bad;
    prev_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    chk({prev_tag, " R9"}, "bit_err", {7'b0, bit_err}, {7'b0, exp_err});
    req_valid = 1'b0; req_op = 3'd7; stat_evt = 5'b0;
    @(posedge clk);
    exp_err  = 1'b0;
    prev_tag = "idle";
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd7; req_addr = 8'h00;
    req_bit = 3'd0; req_wdata = 8'h00; stat_evt = 5'b0;
    m_gpr[0] = 8'h00; m_gpr[1] = 8'h00; m_gpr[2] = 8'h00;
    m_stat = 5'b0; m_ext = 4'h0; exp_err = 1'b0; prev_tag = "reset R12";
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R12: reset state
    op(PRD, 8'h1E, 0, 0, 0, "R12");
    op(PRD, 8'h2A, 0, 0, 0, "R12");
    op(PRD, 8'h2B, 0, 0, 0, "R12");
    op(PRD, 8'h15, 0, 0, 0, "R12");
    op(DRD, 8'hA0, 0, 0, 0, "R12");
    // R1: port window, upper address bits ignored
    op(PWR, 8'h1E, 0, 8'hA5, 0, "R1");
    op(PRD, 8'hDE, 0, 0, 0, "R1");
    // R2: data window aliases I/O + 0x20
    op(DWR, 8'h4A, 0, 8'h3C, 0, "R2");
    op(PRD, 8'h2A, 0, 0, 0, "R2");
    op(PWR, 8'h2B, 0, 8'h77, 0, "R2");
    op(DRD, 8'h4B, 0, 0, 0, "R2");
    op(DRD, 8'h3E, 0, 0, 0, "R2");
    // R3: low data addresses go to the memory port
    op(DWR, 8'h1E, 0, 8'h99, 0, "R3");
    op(DRD, 8'h05, 0, 0, 0, "R3");
    op(PRD, 8'h1E, 0, 0, 0, "R3");
    // R4 / R8: extended register, data-only and 4 bits wide
    op(DWR, 8'hA0, 0, 8'hFF, 0, "R4");
    op(DRD, 8'hA0, 0, 0, 0, "R8");
    op(PWR, 8'hC0, 0, 8'h00, 0, "R4");
    op(PWR, 8'hE0, 0, 8'h00, 0, "R4");
    op(DRD, 8'hA0, 0, 0, 0, "R4");
    // R5: single-bit strobes on a general register
    op(BCLR, 8'h1E, 0, 0, 0, "R5");
    op(BSET, 8'h1E, 1, 0, 0, "R5");
    op(BSET, 8'h1E, 6, 0, 0, "R5");
    op(PRD, 8'h1E, 0, 0, 0, "R5");
    // R6: write-one-to-clear status
    op(PRD, 8'h15, 0, 0, 5'b10111, "R6");
    op(PRD, 8'h15, 0, 0, 0, "R6");
    op(BSET, 8'h15, 1, 0, 0, "R6");
    op(BCLR, 8'h15, 4, 0, 0, "R6");
    op(PRD, 8'h15, 0, 0, 0, "R6");
    op(DWR, 8'h35, 0, 8'h05, 0, "R6");
    op(PRD, 8'h15, 0, 0, 0, "R6");
    // R7: event and clear of the same flag in one cycle
    op(BSET, 8'h15, 4, 0, 5'b10000, "R7");
    op(PRD, 8'h15, 0, 0, 0, "R7");
    op(PWR, 8'h15, 0, 8'hFF, 5'b00110, "R7");
    op(PRD, 8'h15, 0, 0, 0, "R7");
    // R8: reserved status bits
    op(PWR, 8'h15, 0, 8'hE0, 5'b11111, "R8");
    op(PRD, 8'h15, 0, 0, 0, "R8");
    // R9: bit operations above 0x1F
    op(BSET, 8'h2A, 0, 0, 0, "R9");
    op(BCLR, 8'h2B, 0, 0, 0, "R9");
    op(PRD, 8'h2A, 0, 0, 0, "R9");
    op(BTST, 8'h30, 2, 0, 0, "R9");
    op(PRD, 8'h2B, 0, 0, 0, "R9");
    // R10: bit test is combinational and harmless
    op(BTST, 8'h1E, 1, 0, 0, "R10");
    op(BTST, 8'h1E, 0, 0, 0, "R10");
    op(BTST, 8'h15, 3, 0, 0, "R10");
    op(BTST, 8'h15, 7, 0, 0, "R10");
    op(PRD, 8'h1E, 0, 0, 0, "R10");
    // R11: unmapped addresses
    op(PWR, 8'h01, 0, 8'hFF, 0, "R11");
    op(PRD, 8'h01, 0, 0, 0, "R11");
    op(DWR, 8'hC0, 0, 8'h5A, 0, "R11");
    op(DRD, 8'hC0, 0, 0, 0, "R11");
    op(BSET, 8'h02, 3, 0, 0, "R11");
    op(PRD, 8'h02, 0, 0, 0, "R11");
    idle();
    idle();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule